// File: doc/BRIEF.md
# Tamper Monitor Security State Machine

This block keeps the security condition of a battery-backed unit. Two sticky indicators, non-valid and failure, are held in the battery domain. Between them they describe three conditions: valid (both clear), failed (failure set), and recoverable (both set). Ten digital event inputs are each qualified by an enable bit in a tamper configuration register. They cover mesh, two external pins, boot source, alarm, temperature, clock, voltage, and the two counter overflow reports. Any qualified event latches its own status flag and drives the unit into failure. While failure is set, the freeze output tells the time and monotonic counters to stop, so the moment of the event stays recorded.

A control register carries sticky lock bits. Soft locks last until the next system power-on reset. Hard locks last until the next battery power-on reset. The battery reset and the system reset are separate synchronous inputs. Software leaves the recoverable condition by writing 1s to the failure and non-valid bit positions of the status register. Failure can only be cleared while non-valid is set, and non-valid only falls once failure is gone.

Top module: `tamper_sec_fsm`

## Requirements
- R1: While `bat_rst` is high, on the next edge non-valid is set, failure is cleared, every event flag is cleared, and the configuration and control registers become zero. After reset `stat_q` reads 32'h0000_0002.
- R2: An event input whose configuration enable (same bit index, 0..9) is 1 sets its status flag and failure at the next edge. Event i below 8 maps to status bit 16+i, event 8 to bit 2 and event 9 to bit 3. An event whose enable is 0 changes nothing.
- R3: `freeze` and `viol_irq` are high exactly while failure (status bit 0) is set.
- R4: A status write with bit 0 set clears failure only if non-valid (status bit 1) is set at that time. With non-valid clear, failure stays set.
- R5: A `sys_rst` pulse while failure is set and tamper-config hard lock (control bit 30) is clear sets non-valid and keeps failure and all event flags.
- R6: A `sys_rst` pulse while control bit 30 is set leaves non-valid clear, so the unit stays failed and software cannot clear it.
- R7: A status write with bit 1 set clears non-valid only if failure is clear after the same write. Writing 32'h3 from the recoverable condition returns the unit to valid. Writing 32'h2 while failure remains is ignored.
- R8: Writes to the configuration register are ignored while control bit 29 (soft) or bit 30 (hard) is set.
- R9: Control bits 30, 29, 27, 20, 19, 18, 17 and 16 are set-only. `sys_rst` clears the soft ones (29, 27, 19, 17). The hard ones (30, 20, 18, 16) are cleared only by `bat_rst`. Bits 3 and 2 are plain read/write. All other control bits read 0.
- R10: While control bit 16 (failure hard lock) is set, a status write cannot clear failure, even in the recoverable condition.
- R11: An event flag is cleared by writing 1 to its status bit, but only while non-valid is set.
- R12: A qualified event in the same cycle as a clearing status write wins. Failure and its flag stay set, and so does non-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bat_rst | input | 1 | Battery power-on reset, synchronous, active high |
| sys_rst | input | 1 | System power-on reset, synchronous, active high |
| tamper_evt | input | 10 | Event inputs, index matches configuration enable bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 configuration, 1 control, 2 status |
| wr_data | input | 32 | Write data |
| cfg_q | output | 10 | Tamper configuration register |
| ctrl_q | output | 32 | Control and lock register |
| stat_q | output | 32 | Status register |
| freeze | output | 1 | Counter halt request |
| viol_irq | output | 1 | Security violation interrupt |

## Verification
The embedded properties check, on every cycle, the rules that order the state changes. Failure only rises after a qualified event. It only falls from the recoverable condition with the failure hard lock clear. Non-valid only falls with failure gone and only rises without the tamper-config hard lock. Hard locks never drop, the configuration stays put under a lock, and flags only drop under a permitted clear. The directed scenarios are what show the data values: the exact bit position each event lands on, disabled events being ignored, soft locks vanishing at system reset while hard ones remain, the same-cycle event-versus-clear race, and the full recovery sequences after each reset kind.

// File: rtl/tms_pkg.sv
package tms_pkg;

    parameter int NUM_EVT = 10;
    parameter int DW      = 32;

    // status bit positions
    localparam int ST_FAIL = 0;
    localparam int ST_NV   = 1;

    // control bit positions
    localparam int CT_TDC_HL = 30;
    localparam int CT_TDC_SL = 29;
    localparam int CT_KEY_SL = 27;
    localparam int CT_MC_HL  = 20;
    localparam int CT_MC_SL  = 19;
    localparam int CT_TC_HL  = 18;
    localparam int CT_TC_SL  = 17;
    localparam int CT_FS_HL  = 16;
    localparam int CT_TCE    = 3;
    localparam int CT_MCE    = 2;

    localparam logic [DW-1:0] HARD_MASK =
        (32'd1 << CT_TDC_HL) | (32'd1 << CT_MC_HL) |
        (32'd1 << CT_TC_HL)  | (32'd1 << CT_FS_HL);
    localparam logic [DW-1:0] SOFT_MASK =
        (32'd1 << CT_TDC_SL) | (32'd1 << CT_KEY_SL) |
        (32'd1 << CT_MC_SL)  | (32'd1 << CT_TC_SL);
    localparam logic [DW-1:0] LOCK_MASK = HARD_MASK | SOFT_MASK;
    localparam logic [DW-1:0] RW_MASK   = (32'd1 << CT_TCE) | (32'd1 << CT_MCE);

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic            en;
        reg_sel_e        sel;
        logic [DW-1:0]   data;
    } wr_req_t;

    typedef struct packed {
        logic nonvalid;
        logic failure;
    } sec_state_t;

    // status bit that reports event i
    function automatic int flag_pos(input int i);
        if (i < 8)       return 16 + i;
        else if (i == 8) return 2;
        else             return 3;
    endfunction

endpackage

// File: rtl/tms_lock_regs.sv
module tms_lock_regs
    import tms_pkg::*;
(
    input  logic                clk,
    input  logic                bat_rst,
    input  logic                sys_rst,
    input  wr_req_t             wr,
    output logic [NUM_EVT-1:0]  cfg_q,
    output logic [DW-1:0]       ctrl_q
);

    logic cfg_lock;
    logic ctrl_wr;
    logic cfg_wr;

    assign cfg_lock = ctrl_q[CT_TDC_SL] | ctrl_q[CT_TDC_HL];
    assign ctrl_wr  = wr.en && (wr.sel == SEL_CTRL) && !sys_rst;
    assign cfg_wr   = wr.en && (wr.sel == SEL_CFG) && !sys_rst && !cfg_lock;

    always_ff @(posedge clk) begin
        if (bat_rst) begin
            ctrl_q <= '0;
        end else if (sys_rst) begin
            ctrl_q <= ctrl_q & ~SOFT_MASK;
        end else if (ctrl_wr) begin
            ctrl_q <= ((ctrl_q | wr.data) & LOCK_MASK) | (wr.data & RW_MASK);
        end
    end

    always_ff @(posedge clk) begin
        if (bat_rst) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= wr.data[NUM_EVT-1:0];
        end
    end

    // R9: hard locks never drop outside battery reset
    assert_hard_sticky_R9: assert property (@(posedge clk) disable iff (bat_rst)
        !$past(bat_rst) |-> ((($past(ctrl_q) & HARD_MASK) & ~ctrl_q) == '0));

    // R8: configuration holds while a tamper-config lock was set
    assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (bat_rst)
        (!$past(bat_rst) && $past(cfg_lock)) |-> $stable(cfg_q));

endmodule

// File: rtl/tms_event_latch.sv
module tms_event_latch
    import tms_pkg::*;
(
    input  logic                clk,
    input  logic                bat_rst,
    input  logic [NUM_EVT-1:0]  evt_in,
    input  logic [NUM_EVT-1:0]  evt_en,
    input  logic                clr_ok,
    input  logic [NUM_EVT-1:0]  clr_mask,
    output logic [NUM_EVT-1:0]  flags,
    output logic                hit_any
);

    logic [NUM_EVT-1:0] hit;

    assign hit     = evt_in & evt_en;
    assign hit_any = |hit;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (bat_rst) begin
                flags[i] <= 1'b0;
            end else if (hit[i]) begin
                flags[i] <= 1'b1;
            end else if (clr_ok && clr_mask[i]) begin
                flags[i] <= 1'b0;
            end
        end

        // R11: a flag only drops through a permitted clear
        assert_flag_clear_R11: assert property (@(posedge clk) disable iff (bat_rst)
            (!$past(bat_rst) && $fell(flags[i])) |-> $past(clr_ok));
    end

endmodule

// File: rtl/tms_state.sv
module tms_state
    import tms_pkg::*;
(
    input  logic        clk,
    input  logic        bat_rst,
    input  logic        sys_rst,
    input  logic        hit_any,
    input  logic        stat_wr,
    input  logic        wr_fail,
    input  logic        wr_nv,
    input  logic        tdc_hl,
    input  logic        fs_hl,
    output sec_state_t  st,
    output logic        clr_flags_ok
);

    logic fail_clr;
    logic fail_nxt;
    logic nv_clr;

    assign fail_clr     = stat_wr && wr_fail && st.nonvalid && !fs_hl && !hit_any;
    assign fail_nxt     = hit_any || (st.failure && !fail_clr);
    assign nv_clr       = stat_wr && wr_nv && !fail_nxt;
    assign clr_flags_ok = stat_wr && st.nonvalid;

    always_ff @(posedge clk) begin
        if (bat_rst) begin
            st.nonvalid <= 1'b1;
            st.failure  <= 1'b0;
        end else if (sys_rst) begin
            st.failure  <= st.failure | hit_any;
            st.nonvalid <= st.nonvalid | (st.failure & ~tdc_hl);
        end else begin
            st.failure  <= fail_nxt;
            st.nonvalid <= st.nonvalid & ~nv_clr;
        end
    end

    // R2: failure only rises after a qualified event
    assert_fail_cause_R2: assert property (@(posedge clk) disable iff (bat_rst)
        (!$past(bat_rst) && $rose(st.failure)) |-> $past(hit_any));

    // R4 / R10: failure only falls from recoverable state without hard lock
    assert_fail_clear_R4: assert property (@(posedge clk) disable iff (bat_rst)
        (!$past(bat_rst) && $fell(st.failure)) |-> ($past(st.nonvalid) && !$past(fs_hl)));

    // R7: non-valid is cleared last
    assert_nv_last_R7: assert property (@(posedge clk) disable iff (bat_rst)
        (!$past(bat_rst) && $fell(st.nonvalid)) |-> !st.failure);

    // R6: system reset never restores non-valid under the tamper-config hard lock
    assert_nv_hardlock_R6: assert property (@(posedge clk) disable iff (bat_rst)
        (!$past(bat_rst) && $rose(st.nonvalid)) |-> !$past(tdc_hl));

endmodule

// File: rtl/tamper_sec_fsm.sv
module tamper_sec_fsm
    import tms_pkg::*;
(
    input  logic                clk,
    input  logic                bat_rst,
    input  logic                sys_rst,
    input  logic [NUM_EVT-1:0]  tamper_evt,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [DW-1:0]       wr_data,
    output logic [NUM_EVT-1:0]  cfg_q,
    output logic [DW-1:0]       ctrl_q,
    output logic [DW-1:0]       stat_q,
    output logic                freeze,
    output logic                viol_irq
);

    wr_req_t             wr;
    sec_state_t          st;
    logic [NUM_EVT-1:0]  flags;
    logic [NUM_EVT-1:0]  clr_mask;
    logic                hit_any;
    logic                stat_wr;
    logic                clr_flags_ok;

    assign wr.en   = wr_en;
    assign wr.sel  = reg_sel_e'(wr_sel);
    assign wr.data = wr_data;

    assign stat_wr = wr_en && (wr.sel == SEL_STAT) && !sys_rst;

    always_comb begin
        for (int i = 0; i < NUM_EVT; i++) begin
            clr_mask[i] = wr_data[flag_pos(i)];
        end
    end

    tms_lock_regs u_locks (
        .clk     (clk),
        .bat_rst (bat_rst),
        .sys_rst (sys_rst),
        .wr      (wr),
        .cfg_q   (cfg_q),
        .ctrl_q  (ctrl_q)
    );

    tms_event_latch u_events (
        .clk      (clk),
        .bat_rst  (bat_rst),
        .evt_in   (tamper_evt),
        .evt_en   (cfg_q),
        .clr_ok   (clr_flags_ok),
        .clr_mask (clr_mask),
        .flags    (flags),
        .hit_any  (hit_any)
    );

    tms_state u_state (
        .clk          (clk),
        .bat_rst      (bat_rst),
        .sys_rst      (sys_rst),
        .hit_any      (hit_any),
        .stat_wr      (stat_wr),
        .wr_fail      (wr_data[ST_FAIL]),
        .wr_nv        (wr_data[ST_NV]),
        .tdc_hl       (ctrl_q[CT_TDC_HL]),
        .fs_hl        (ctrl_q[CT_FS_HL]),
        .st           (st),
        .clr_flags_ok (clr_flags_ok)
    );

    always_comb begin
        stat_q = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            stat_q[flag_pos(i)] = flags[i];
        end
        stat_q[ST_NV]   = st.nonvalid;
        stat_q[ST_FAIL] = st.failure;
    end

    assign freeze   = st.failure;
    assign viol_irq = st.failure;

endmodule

// File: tb/tamper_sec_fsm_bench.sv
module tamper_sec_fsm_bench;

    logic        clk = 1'b0;
    logic        bat_rst = 1'b1;
    logic        sys_rst = 1'b0;
    logic [9:0]  tamper_evt = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [9:0]  cfg_q;
    logic [31:0] ctrl_q;
    logic [31:0] stat_q;
    logic        freeze;
    logic        viol_irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tamper_sec_fsm u_tamper_sec_fsm (
        .clk(clk), .bat_rst(bat_rst), .sys_rst(sys_rst), .tamper_evt(tamper_evt),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cfg_q(cfg_q), .ctrl_q(ctrl_q), .stat_q(stat_q),
        .freeze(freeze), .viol_irq(viol_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_evt(input int idx);
        tamper_evt[idx] = 1'b1;
        tick();
        tamper_evt = '0;
    endtask

    task automatic pulse_sys;
        sys_rst = 1'b1;
        tick();
        sys_rst = 1'b0;
    endtask

    task automatic pulse_bat;
        bat_rst = 1'b1;
        tick();
        tick();
        bat_rst = 1'b0;
    endtask

    task automatic t_reset_state;
        chk("R1 stat", stat_q, 32'h2);
        chk("R1 cfg", {22'd0, cfg_q}, 32'h0);
        chk("R1 ctrl", ctrl_q, 32'h0);
        chk("R3 freeze idle", {31'd0, freeze}, 32'h0);
    endtask

    task automatic t_first_valid;
        reg_write(2'd2, 32'h2);
        chk("R7 leave nonvalid", stat_q, 32'h0);
    endtask

    task automatic t_disabled_event;
        pulse_evt(7);
        chk("R2 disabled ignored", stat_q, 32'h0);
        chk("R3 no freeze", {31'd0, freeze}, 32'h0);
    endtask

    task automatic t_enabled_events;
        reg_write(2'd0, 32'h3FF);
        chk("R2 cfg written", {22'd0, cfg_q}, 32'h3FF);
        pulse_evt(0);
        chk("R2 voltage flag", stat_q, 32'h0001_0001);
        chk("R3 freeze", {31'd0, freeze}, 32'h1);
        chk("R3 irq", {31'd0, viol_irq}, 32'h1);
        pulse_evt(8);
        chk("R2 overflow flag", stat_q, 32'h0001_0005);
    endtask

    task automatic t_no_sw_clear;
        reg_write(2'd2, 32'h1);
        chk("R4 failure held", stat_q, 32'h0001_0005);
        reg_write(2'd2, 32'h0001_0004);
        chk("R11 flags held", stat_q, 32'h0001_0005);
    endtask

    task automatic t_sys_recover;
        reg_write(2'd1, 32'h2004_0000);
        chk("R9 locks set", ctrl_q, 32'h2004_0000);
        pulse_sys();
        chk("R5 nonvalid restored", stat_q, 32'h0001_0007);
        chk("R9 soft cleared", ctrl_q, 32'h0004_0000);
        reg_write(2'd2, 32'h2);
        chk("R7 nv-only ignored", stat_q, 32'h0001_0007);
        reg_write(2'd2, 32'h0001_0004);
        chk("R11 flags cleared", stat_q, 32'h3);
        reg_write(2'd2, 32'h3);
        chk("R7 back to valid", stat_q, 32'h0);
        chk("R3 freeze released", {31'd0, freeze}, 32'h0);
    endtask

    task automatic t_cfg_lock;
        reg_write(2'd1, 32'h2000_000C);
        chk("R9 rw bits", ctrl_q, 32'h2004_000C);
        reg_write(2'd0, 32'h0);
        chk("R8 soft lock blocks", {22'd0, cfg_q}, 32'h3FF);
        pulse_sys();
        chk("R9 soft gone", ctrl_q, 32'h0004_000C);
        reg_write(2'd0, 32'h0FF);
        chk("R8 write after unlock", {22'd0, cfg_q}, 32'h0FF);
        reg_write(2'd1, 32'h0);
        chk("R9 locks set-only", ctrl_q, 32'h0004_0000);
    endtask

    task automatic t_fail_hardlock;
        reg_write(2'd1, 32'h0001_0000);
        pulse_evt(9);
        chk("R2 disabled overflow", stat_q, 32'h0);
        pulse_evt(7);
        chk("R2 mesh flag", stat_q, 32'h0080_0001);
        pulse_sys();
        chk("R5 nonvalid after sys", stat_q, 32'h0080_0003);
        chk("R9 hard kept", ctrl_q, 32'h0005_0000);
        reg_write(2'd2, 32'h3);
        chk("R10 failure locked", stat_q, 32'h0080_0003);
    endtask

    task automatic t_race_and_bat;
        pulse_bat();
        t_reset_state();
        reg_write(2'd0, 32'h1);
        pulse_evt(0);
        chk("R2 after bat", stat_q, 32'h0001_0003);
        tamper_evt[0] = 1'b1;
        reg_write(2'd2, 32'h3);
        tamper_evt = '0;
        chk("R12 event wins", stat_q, 32'h0001_0003);
        reg_write(2'd2, 32'h3);
        chk("R7 recovered flag kept", stat_q, 32'h0001_0000);
        reg_write(2'd2, 32'h0001_0000);
        chk("R11 no clear when valid", stat_q, 32'h0001_0000);
    endtask

    task automatic t_tdc_hardlock;
        reg_write(2'd1, 32'h4000_0000);
        pulse_evt(0);
        chk("R2 refail", stat_q, 32'h0001_0001);
        pulse_sys();
        chk("R6 no nonvalid", stat_q, 32'h0001_0001);
        chk("R6 hard kept", ctrl_q, 32'h4000_0000);
        reg_write(2'd2, 32'h3);
        chk("R6 stuck failed", stat_q, 32'h0001_0001);
        reg_write(2'd0, 32'h0);
        chk("R8 hard lock blocks", {22'd0, cfg_q}, 32'h1);
    endtask

    initial begin
        tick();
        tick();
        bat_rst = 1'b0;
        t_reset_state();
        t_first_valid();
        t_disabled_event();
        t_enabled_events();
        t_no_sw_clear();
        t_sys_recover();
        t_cfg_lock();
        t_fail_hardlock();
        t_race_and_bat();
        t_tdc_hardlock();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule